// File: doc/BRIEF.md
# Two-Sided Stencil Test Unit

This block combines a fragment's stored stencil value with the result of an external depth test. It decides whether the fragment survives, and it works out the stencil value to write back. Each fragment brings three things: the stored 8-bit stencil value, a flag that marks it as back-facing, and the depth-test result. The unit compares a masked reference value against the masked stored value. It then picks one of three update operations, depending on whether the stencil test failed, passed while the depth test failed, or passed together with the depth test. The chosen result is merged into the old value under a write mask.

The front and back faces each keep their own reference value, test mask, write mask, compare function and three operations. A two-sided enable decides whether back-facing fragments use the back-face state. All state is loaded through a small write port. The unit has one register stage: results and a valid strobe appear on the cycle after a valid input.

Register map on the write port (`cfg_addr`):
- Address 0, control: bit 0 enables the stencil test, bit 1 enables the stencil write, bit 2 enables two-sided mode.
- Addresses 1 (front) and 3 (back), values: bits 7:0 hold the reference, bits 15:8 the test mask, bits 23:16 the write mask.
- Addresses 2 (front) and 4 (back), functions: bits 2:0 hold the compare function, bits 5:3 the stencil-fail operation, bits 8:6 the depth-fail operation, bits 11:9 the depth-pass operation.
- Addresses 5 to 7 are not used.

Top module: `twoside_stencil`

## Requirements
- R1: The comparison is (reference AND test mask) against (stored AND test mask), with the reference on the left. The compare codes are: 0 always, 1 never, 2 less, 3 equal, 4 less-or-equal, 5 greater, 6 not-equal, 7 greater-or-equal.
- R2: The operation codes are: 0 keep, 1 zero, 2 replace with reference, 3 increment saturating at 255, 4 decrement saturating at 0, 5 increment with wrap, 6 decrement with wrap, 7 bitwise invert.
- R3: A failed stencil test selects the stencil-fail operation. A passed test selects the depth-fail operation when the depth result is 0, and the depth-pass operation when it is 1.
- R4: With writes enabled, the output stencil is (new AND write mask) OR (old AND NOT write mask).
- R5: With the write enable clear, the output stencil equals the input stencil, whatever the operation.
- R6: With the test enable clear, the stencil test counts as passed, and only the depth result chooses the operation.
- R7: When two-sided mode is set, back-facing fragments (`in_back`=1) use the back-face state. When it is clear, every fragment uses the front-face state.
- R8: `out_kill` is 1 when the stencil test fails or the depth result is 0, and 0 otherwise.
- R9: `out_valid`, `out_stencil` and `out_kill` change one cycle after a valid input. When `in_valid` is low, `out_valid` is 0 on the next cycle and `out_stencil` and `out_kill` hold their values.
- R10: A write on the configuration port takes effect from the next cycle. A fragment presented in the same cycle as the write uses the old state.
- R11: After reset all state is zero, and `out_valid`, `out_stencil` and `out_kill` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_data | input | 32 | Configuration write data |
| in_valid | input | 1 | Fragment valid |
| in_stencil | input | 8 | Stored stencil value |
| in_back | input | 1 | Fragment is back-facing |
| in_depth_pass | input | 1 | External depth test passed |
| out_valid | output | 1 | Result valid |
| out_stencil | output | 8 | Stencil value to write back |
| out_kill | output | 1 | Fragment discarded |

## Verification
A configuration write and a fragment can land in the same cycle. The fragment must then be judged with the state that was in place before the write. The bench provokes this by driving a write to the front function register in the same cycle as a valid fragment. It checks that the result follows the old depth-pass operation, and that the following fragment follows the new one.

// File: rtl/twoside_stencil.sv
module twoside_stencil #(
  parameter int SW = 8,
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_data,
  input  logic          in_valid,
  input  logic [SW-1:0] in_stencil,
  input  logic          in_back,
  input  logic          in_depth_pass,
  output logic          out_valid,
  output logic [SW-1:0] out_stencil,
  output logic          out_kill
);
  localparam int OPW = 3;
  localparam logic [SW-1:0] SMAX = '1;

  logic          test_en_q, wr_en_q, two_q;
  logic [SW-1:0] ref_q   [2];
  logic [SW-1:0] tmask_q [2];
  logic [SW-1:0] wmask_q [2];
  logic [OPW-1:0] func_q [2];
  logic [OPW-1:0] sf_q   [2];
  logic [OPW-1:0] zf_q   [2];
  logic [OPW-1:0] zp_q   [2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      test_en_q <= 1'b0;
      wr_en_q   <= 1'b0;
      two_q     <= 1'b0;
      for (int i = 0; i < 2; i++) begin
        ref_q[i]   <= '0;
        tmask_q[i] <= '0;
        wmask_q[i] <= '0;
        func_q[i]  <= '0;
        sf_q[i]    <= '0;
        zf_q[i]    <= '0;
        zp_q[i]    <= '0;
      end
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: {two_q, wr_en_q, test_en_q} <= cfg_data[2:0];
        3'd1, 3'd3: begin
          ref_q[cfg_addr[1]]   <= cfg_data[SW-1:0];
          tmask_q[cfg_addr[1]] <= cfg_data[2*SW-1:SW];
          wmask_q[cfg_addr[1]] <= cfg_data[3*SW-1:2*SW];
        end
        3'd2, 3'd4: begin
          func_q[cfg_addr[2]] <= cfg_data[2:0];
          sf_q[cfg_addr[2]]   <= cfg_data[5:3];
          zf_q[cfg_addr[2]]   <= cfg_data[8:6];
          zp_q[cfg_addr[2]]   <= cfg_data[11:9];
        end
        default: ;
      endcase
    end
  end

  logic          face;
  logic [SW-1:0] lhs, rhs, act_wmask, nxt, merged;
  logic          cmp_ok, pass;
  logic [OPW-1:0] op;

  assign face      = two_q & in_back;
  assign lhs       = ref_q[face] & tmask_q[face];
  assign rhs       = in_stencil & tmask_q[face];
  assign act_wmask = wmask_q[face];

  always_comb begin
    case (func_q[face])
      3'd0: cmp_ok = 1'b1;
      3'd1: cmp_ok = 1'b0;
      3'd2: cmp_ok = lhs <  rhs;
      3'd3: cmp_ok = lhs == rhs;
      3'd4: cmp_ok = lhs <= rhs;
      3'd5: cmp_ok = lhs >  rhs;
      3'd6: cmp_ok = lhs != rhs;
      default: cmp_ok = lhs >= rhs;
    endcase
  end

  assign pass = cmp_ok | ~test_en_q;
  assign op   = !pass ? sf_q[face] : (in_depth_pass ? zp_q[face] : zf_q[face]);

  always_comb begin
    case (op)
      3'd0: nxt = in_stencil;
      3'd1: nxt = '0;
      3'd2: nxt = ref_q[face];
      3'd3: nxt = (in_stencil == SMAX) ? SMAX : in_stencil + 1'b1;
      3'd4: nxt = (in_stencil == '0) ? '0 : in_stencil - 1'b1;
      3'd5: nxt = in_stencil + 1'b1;
      3'd6: nxt = in_stencil - 1'b1;
      default: nxt = ~in_stencil;
    endcase
  end

  assign merged = wr_en_q ? ((nxt & act_wmask) | (in_stencil & ~act_wmask)) : in_stencil;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_stencil <= '0;
      out_kill    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_stencil <= merged;
        out_kill    <= ~pass | ~in_depth_pass;
      end
    end
  end
endmodule

module stencil_chk #(parameter int SW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [SW-1:0] in_stencil,
  input logic          in_depth_pass,
  input logic          out_valid,
  input logic [SW-1:0] out_stencil,
  input logic          out_kill,
  input logic          test_en_q,
  input logic          wr_en_q,
  input logic [SW-1:0] act_wmask
);
  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && in_valid) |=> out_valid);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !in_valid) |=> (!out_valid && $stable(out_stencil) && $stable(out_kill)));
  // R5
  wr_off_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && in_valid && !wr_en_q) |=> (out_stencil == $past(in_stencil)));
  // R4
  wmask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && in_valid) |=> (((out_stencil ^ $past(in_stencil)) & ~$past(act_wmask)) == '0));
  // R8
  depth_fail_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && in_valid && !in_depth_pass) |=> out_kill);
  // R6
  test_off_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && in_valid && !test_en_q && in_depth_pass) |=> !out_kill);
endmodule

bind twoside_stencil stencil_chk #(.SW(SW)) u_chk (.*);

// File: tb/sim_twoside_stencil.sv
module sim_twoside_stencil;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_addr = 0;
  logic [31:0] cfg_data = 0;
  logic        in_valid = 0, in_back = 0, in_depth_pass = 0;
  logic [7:0]  in_stencil = 0;
  logic        out_valid, out_kill;
  logic [7:0]  out_stencil;

  int checks = 0, errors = 0;

  bit       m_test, m_wr, m_two;
  bit [7:0] m_ref[2], m_tm[2], m_wm[2];
  bit [2:0] m_fn[2], m_sf[2], m_zf[2], m_zp[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  twoside_stencil u0 (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model(input bit [7:0] s, input bit back, input bit dp,
                                output bit [7:0] res, output bit kill);
    int f = (m_two && back) ? 1 : 0;
    bit [7:0] l = m_ref[f] & m_tm[f];
    bit [7:0] r = s & m_tm[f];
    bit ok, pass;
    bit [2:0] op;
    bit [7:0] n;
    case (m_fn[f])
      0: ok = 1; 1: ok = 0; 2: ok = l < r; 3: ok = l == r;
      4: ok = l <= r; 5: ok = l > r; 6: ok = l != r; default: ok = l >= r;
    endcase
    pass = ok || !m_test;
    op = !pass ? m_sf[f] : (dp ? m_zp[f] : m_zf[f]);
    case (op)
      0: n = s; 1: n = 0; 2: n = m_ref[f];
      3: n = (s == 8'hFF) ? 8'hFF : s + 8'd1;
      4: n = (s == 8'h00) ? 8'h00 : s - 8'd1;
      5: n = s + 8'd1; 6: n = s - 8'd1; default: n = ~s;
    endcase
    res = m_wr ? ((n & m_wm[f]) | (s & ~m_wm[f])) : s;
    kill = !pass || !dp;
  endfunction

  function automatic void shadow(input bit [2:0] a, input bit [31:0] d);
    case (a)
      0: {m_two, m_wr, m_test} = d[2:0];
      1, 3: begin m_ref[a[1]] = d[7:0]; m_tm[a[1]] = d[15:8]; m_wm[a[1]] = d[23:16]; end
      2, 4: begin m_fn[a[2]] = d[2:0]; m_sf[a[2]] = d[5:3]; m_zf[a[2]] = d[8:6]; m_zp[a[2]] = d[11:9]; end
      default: ;
    endcase
  endfunction

  task automatic wr(input bit [2:0] a, input bit [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
    shadow(a, d);
  endtask

  function automatic bit [31:0] vals(bit [7:0] rf, bit [7:0] tm, bit [7:0] wm);
    return {8'h00, wm, tm, rf};
  endfunction
  function automatic bit [31:0] fns(bit [2:0] fn, bit [2:0] sf, bit [2:0] zf, bit [2:0] zp);
    return {20'h0, zp, zf, sf, fn};
  endfunction

  task automatic frag(string tag, input bit [7:0] s, input bit back, input bit dp);
    bit [7:0] es; bit ek;
    model(s, back, dp, es, ek);
    in_valid = 1; in_stencil = s; in_back = back; in_depth_pass = dp;
    @(negedge clk);
    in_valid = 0;
    chk(tag, out_valid, 1);
    chk(tag, out_stencil, es);
    chk(tag, out_kill, ek);
  endtask

  task automatic t_reset;
    chk("R11", out_valid, 0);
    chk("R11", out_stencil, 0);
    chk("R11", out_kill, 0);
    frag("R11", 8'h9C, 0, 1);
  endtask

  task automatic t_compare;
    bit [7:0] sv[3] = '{8'hA5, 8'h13, 8'hF9};
    wr(0, 3'b011);
    wr(1, vals(8'h35, 8'h0F, 8'hFF));
    for (int fn = 0; fn < 8; fn++) begin
      wr(2, fns(fn[2:0], 3'd1, 3'd0, 3'd7));
      foreach (sv[i]) frag("R1", sv[i], 0, 1);
    end
  endtask

  task automatic t_ops;
    bit [7:0] sv[3] = '{8'h00, 8'hFF, 8'h7C};
    wr(1, vals(8'h5A, 8'hFF, 8'hFF));
    for (int op = 0; op < 8; op++) begin
      wr(2, fns(3'd0, 3'd0, 3'd0, op[2:0]));
      foreach (sv[i]) frag("R2", sv[i], 0, 1);
    end
  endtask

  task automatic t_paths;
    wr(1, vals(8'h40, 8'hFF, 8'hFF));
    wr(2, fns(3'd3, 3'd2, 3'd7, 3'd5));
    chk("R3", m_sf[0], 2);
    frag("R3", 8'h40, 0, 1);
    frag("R3", 8'h40, 0, 0);
    frag("R3", 8'h41, 0, 1);
  endtask

  task automatic t_wmask;
    wr(1, vals(8'h00, 8'hFF, 8'h0F));
    wr(2, fns(3'd0, 3'd0, 3'd0, 3'd7));
    frag("R4", 8'h3C, 0, 1);
    chk("R4", out_stencil, 8'h33);
  endtask

  task automatic t_wrdis;
    wr(0, 3'b001);
    wr(1, vals(8'h00, 8'hFF, 8'hFF));
    frag("R5", 8'h3C, 0, 1);
    chk("R5", out_stencil, 8'h3C);
  endtask

  task automatic t_testdis;
    wr(0, 3'b010);
    wr(2, fns(3'd1, 3'd1, 3'd7, 3'd5));
    frag("R6", 8'h10, 0, 1);
    chk("R6", out_stencil, 8'h11);
    frag("R6", 8'h10, 0, 0);
    chk("R6", out_stencil, 8'hEF);
  endtask

  task automatic t_kill;
    wr(0, 3'b011);
    wr(2, fns(3'd0, 3'd0, 3'd0, 3'd0));
    frag("R8", 8'h22, 0, 0);
    chk("R8", out_kill, 1);
    frag("R8", 8'h22, 0, 1);
    chk("R8", out_kill, 0);
  endtask

  task automatic t_twoside;
    wr(1, vals(8'h01, 8'hFF, 8'hFF));
    wr(2, fns(3'd0, 3'd0, 3'd0, 3'd5));
    wr(3, vals(8'h77, 8'hFF, 8'hFF));
    wr(4, fns(3'd1, 3'd2, 3'd0, 3'd0));
    wr(0, 3'b111);
    frag("R7", 8'h05, 1, 1);
    chk("R7", out_stencil, 8'h77);
    frag("R7", 8'h05, 0, 1);
    wr(0, 3'b011);
    frag("R7", 8'h05, 1, 1);
    chk("R7", out_stencil, 8'h06);
  endtask

  task automatic t_latency;
    frag("R9", 8'h80, 0, 1);
    @(negedge clk);
    chk("R9", out_valid, 0);
    chk("R9", out_stencil, 8'h81);
    chk("R9", out_kill, 0);
  endtask

  task automatic t_samecycle;
    bit [7:0] es; bit ek;
    wr(2, fns(3'd0, 3'd0, 3'd0, 3'd7));
    model(8'h0F, 0, 1, es, ek);
    cfg_we = 1; cfg_addr = 2; cfg_data = fns(3'd0, 3'd0, 3'd0, 3'd1);
    in_valid = 1; in_stencil = 8'h0F; in_back = 0; in_depth_pass = 1;
    @(negedge clk);
    cfg_we = 0; in_valid = 0;
    shadow(2, fns(3'd0, 3'd0, 3'd0, 3'd1));
    chk("R10", out_stencil, es);
    chk("R10", out_stencil, 8'hF0);
    frag("R10", 8'h0F, 0, 1);
    chk("R10", out_stencil, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_compare;
    t_ops;
    t_paths;
    t_wmask;
    t_wrdis;
    t_testdis;
    t_kill;
    t_twoside;
    t_latency;
    t_samecycle;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule